// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block drives a set of general-purpose I/O ports through a small register interface. One short port has no direction register. Two of its pins are open-drain, and the rest of its pins are driven only by peripherals. The remaining ports are full width. Each of their pins has a data latch and a direction bit. Every pin produces an output enable and an output value for its pad, and it takes in the pad level through a two-flop synchronizer.

Peripheral modules can take over any pin through an override enable and an override value. A two-bit operating mode hands a contiguous group of the wide ports to an external system bus. In the two external-bus modes the bus drives those pins. In the two internal modes they act as ordinary GPIO.

A read of a data address returns the synchronized pad levels, not the latch contents. Because of this, a read-modify-write on the open-drain port can capture a level that an external device is holding low and write it back into the latch.

Top module: `gpio_mux_port`

## Requirements
- R1: On reset every direction bit is 1 (input) and every wide-port latch is 0. The short-port latch is 1 on its open-drain bits (pins 2 and 3) and 0 elsewhere. No pad output enable is active after reset.
- R2: With `wr_en` high at a clock edge, `wdata` is stored at `addr`. The address map is: address 0 is the short-port latch, address 1+k is the latch of wide port k, and address 1+NUM_DPORTS+k is the direction register of wide port k. `rdata` is combinational. A direction address returns the direction bits, and an unmapped address returns 0.
- R3: A read of a data address returns the pad levels through two synchronizer flops. A pad change made between two edges appears on `rdata` after the second following rising edge, and not after the first.
- R4: With no override active, a direction bit of 0 enables the pin's output with the latch value. A direction bit of 1 disables the output.
- R5: The open-drain pins never drive high. With no override, latch bit 0 enables the output with a low level, and latch bit 1 disables the output.
- R6: A write changes only the latch or direction register it addresses. Short-port pins that are not open-drain are never driven from the latch.
- R7: A set `*_alt_en` bit forces the pin to the peripheral value whatever its direction bit. On an open-drain pin the peripheral value 0 pulls the pin low and the value 1 releases it.
- R8: `pa_sync`/`px_sync` carry the synchronized pad levels to input-type peripherals. A pin configured as an output therefore presents the value the port drives.
- R9: In modes 2'b10 and 2'b11, wide ports BUS_LO..BUS_HI take `bus_oe`/`bus_out`, and this takes priority over peripheral overrides and direction bits. In modes 2'b00 and 2'b01 those ports behave as GPIO. Other ports are unaffected by the mode.
- R10: While an external device holds a released open-drain pin low, a read of the short port returns 0 on that bit. Writing that read value back with another bit changed turns the pin into an active low driver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | PORT_W | Write data |
| rdata | output | PORT_W | Read data (combinational) |
| bus_mode | input | 2 | Operating mode; bit 1 set selects an external-bus mode |
| pa_pad_in | input | PA_W | Short-port pad levels |
| pa_pad_oe | output | PA_W | Short-port output enables |
| pa_pad_out | output | PA_W | Short-port output values |
| pa_alt_en | input | PA_W | Short-port peripheral override enables |
| pa_alt_out | input | PA_W | Short-port peripheral drive values |
| pa_sync | output | PA_W | Synchronized short-port levels to peripherals |
| px_pad_in | input | NUM_DPORTS*PORT_W | Wide-port pad levels |
| px_pad_oe | output | NUM_DPORTS*PORT_W | Wide-port output enables |
| px_pad_out | output | NUM_DPORTS*PORT_W | Wide-port output values |
| px_alt_en | input | NUM_DPORTS*PORT_W | Wide-port peripheral override enables |
| px_alt_out | input | NUM_DPORTS*PORT_W | Wide-port peripheral drive values |
| px_sync | output | NUM_DPORTS*PORT_W | Synchronized wide-port levels to peripherals |
| bus_oe | input | NUM_BUS*PORT_W | System-bus output enables for the bus group |
| bus_out | input | NUM_BUS*PORT_W | System-bus output values for the bus group |

## Verification
The assertions check the following on every cycle:
- the override priorities: the bus wins in external modes, and a peripheral wins over direction;
- that open-drain pins never drive high;
- that short-port pins without open-drain capability are driven only by a peripheral;
- that a direction write is reflected in the output enables on the next cycle;
- that a data read equals the pad level two edges earlier.

Only the bench scenarios can show the other behaviours:
- the reset contents;
- the read-versus-latch distinction under a pad loopback;
- the exact synchronizer latency boundary;
- the return to GPIO when the mode goes back to an internal one;
- the read-modify-write hazard against a modelled pull-up and external pull-down.

// File: rtl/gpio_mux_pkg.sv
`timescale 1ns/1ps
package gpio_mux_pkg;
    typedef enum logic [1:0] {
        MODE_INT_PLAIN = 2'b00,
        MODE_INT_PROT  = 2'b01,
        MODE_EXT_MCU   = 2'b10,
        MODE_EXT_PROC  = 2'b11
    } bus_mode_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_odport.sv
`timescale 1ns/1ps
module gpio_odport #(
    parameter int             W       = 6,
    parameter logic [W-1:0]   OD_MASK = 6'b001100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_data,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] alt_en,
    input  logic [W-1:0] alt_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] sync_q
);
    logic [W-1:0] latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       latch_q <= OD_MASK;
        else if (wr_data) latch_q <= wdata;
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (OD_MASK[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = alt_en[i] ? ~alt_out[i] : ~latch_q[i];
            end else begin
                pad_oe[i]  = alt_en[i];
                pad_out[i] = alt_en[i] & alt_out[i];
            end
        end
    end

    gpio_sync #(.W(W)) sync_i (.clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q));
endmodule

// File: rtl/gpio_dport.sv
`timescale 1ns/1ps
module gpio_dport #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_data,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] alt_en,
    input  logic [W-1:0] alt_out,
    input  logic         bus_sel,
    input  logic [W-1:0] bus_oe,
    input  logic [W-1:0] bus_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] dir_q
);
    logic [W-1:0] latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '1;
        end else begin
            if (wr_data) latch_q <= wdata;
            if (wr_dir)  dir_q   <= wdata;
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (bus_sel) begin
                pad_oe[i]  = bus_oe[i];
                pad_out[i] = bus_out[i];
            end else if (alt_en[i]) begin
                pad_oe[i]  = 1'b1;
                pad_out[i] = alt_out[i];
            end else begin
                pad_oe[i]  = ~dir_q[i];
                pad_out[i] = latch_q[i];
            end
        end
    end

    gpio_sync #(.W(W)) sync_i (.clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q));
endmodule

// File: rtl/gpio_mux_port.sv
`timescale 1ns/1ps
module gpio_mux_port
    import gpio_mux_pkg::*;
#(
    parameter int              PA_W       = 6,
    parameter logic [PA_W-1:0] PA_OD_MASK = 6'b001100,
    parameter int              PORT_W     = 8,
    parameter int              NUM_DPORTS = 4,
    parameter int              BUS_LO     = 1,
    parameter int              BUS_HI     = 3,
    localparam int             NUM_BUS    = BUS_HI - BUS_LO + 1,
    localparam int             ADDR_W     = $clog2(2 * NUM_DPORTS + 1),
    localparam int             PX_W       = NUM_DPORTS * PORT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [PORT_W-1:0]         wdata,
    output logic [PORT_W-1:0]         rdata,
    input  logic [1:0]                bus_mode,
    input  logic [PA_W-1:0]           pa_pad_in,
    output logic [PA_W-1:0]           pa_pad_oe,
    output logic [PA_W-1:0]           pa_pad_out,
    input  logic [PA_W-1:0]           pa_alt_en,
    input  logic [PA_W-1:0]           pa_alt_out,
    output logic [PA_W-1:0]           pa_sync,
    input  logic [PX_W-1:0]           px_pad_in,
    output logic [PX_W-1:0]           px_pad_oe,
    output logic [PX_W-1:0]           px_pad_out,
    input  logic [PX_W-1:0]           px_alt_en,
    input  logic [PX_W-1:0]           px_alt_out,
    output logic [PX_W-1:0]           px_sync,
    input  logic [NUM_BUS*PORT_W-1:0] bus_oe,
    input  logic [NUM_BUS*PORT_W-1:0] bus_out
);
    bus_mode_e mode;
    logic      ext_bus;
    logic [PX_W-1:0] dir_all;

    always_comb begin
        mode = bus_mode_e'(bus_mode);
        unique case (mode)
            MODE_INT_PLAIN, MODE_INT_PROT: ext_bus = 1'b0;
            MODE_EXT_MCU,   MODE_EXT_PROC: ext_bus = 1'b1;
        endcase
    end

    gpio_odport #(.W(PA_W), .OD_MASK(PA_OD_MASK)) pa_i (
        .clk(clk), .rst_n(rst_n),
        .wr_data(wr_en && addr == '0),
        .wdata(wdata[PA_W-1:0]),
        .pad_in(pa_pad_in), .alt_en(pa_alt_en), .alt_out(pa_alt_out),
        .pad_oe(pa_pad_oe), .pad_out(pa_pad_out), .sync_q(pa_sync)
    );

    for (genvar k = 0; k < NUM_DPORTS; k++) begin : g_dport
        logic              in_bus;
        logic [PORT_W-1:0] b_oe, b_out;
        if (k >= BUS_LO && k <= BUS_HI) begin : g_bus
            assign in_bus = ext_bus;
            assign b_oe   = bus_oe[(k-BUS_LO)*PORT_W +: PORT_W];
            assign b_out  = bus_out[(k-BUS_LO)*PORT_W +: PORT_W];
        end else begin : g_gpio
            assign in_bus = 1'b0;
            assign b_oe   = '0;
            assign b_out  = '0;
        end
        gpio_dport #(.W(PORT_W)) port_i (
            .clk(clk), .rst_n(rst_n),
            .wr_data(wr_en && addr == ADDR_W'(k + 1)),
            .wr_dir(wr_en && addr == ADDR_W'(NUM_DPORTS + 1 + k)),
            .wdata(wdata),
            .pad_in(px_pad_in[k*PORT_W +: PORT_W]),
            .alt_en(px_alt_en[k*PORT_W +: PORT_W]),
            .alt_out(px_alt_out[k*PORT_W +: PORT_W]),
            .bus_sel(in_bus), .bus_oe(b_oe), .bus_out(b_out),
            .pad_oe(px_pad_oe[k*PORT_W +: PORT_W]),
            .pad_out(px_pad_out[k*PORT_W +: PORT_W]),
            .sync_q(px_sync[k*PORT_W +: PORT_W]),
            .dir_q(dir_all[k*PORT_W +: PORT_W])
        );
    end

    always_comb begin
        rdata = '0;
        if (addr == '0) rdata = PORT_W'(pa_sync);
        for (int k = 0; k < NUM_DPORTS; k++) begin
            if (addr == ADDR_W'(k + 1))              rdata = px_sync[k*PORT_W +: PORT_W];
            if (addr == ADDR_W'(NUM_DPORTS + 1 + k)) rdata = dir_all[k*PORT_W +: PORT_W];
        end
    end
endmodule

// File: rtl/gpio_mux_port_chk.sv
`timescale 1ns/1ps
module gpio_mux_port_chk #(
    parameter int              PA_W       = 6,
    parameter logic [PA_W-1:0] PA_OD_MASK = 6'b001100,
    parameter int              PORT_W     = 8,
    parameter int              NUM_DPORTS = 4,
    parameter int              BUS_LO     = 1,
    parameter int              BUS_HI     = 3,
    localparam int             NUM_BUS    = BUS_HI - BUS_LO + 1,
    localparam int             ADDR_W     = $clog2(2 * NUM_DPORTS + 1),
    localparam int             PX_W       = NUM_DPORTS * PORT_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         addr,
    input logic [PORT_W-1:0]         wdata,
    input logic [PORT_W-1:0]         rdata,
    input logic [1:0]                bus_mode,
    input logic [PA_W-1:0]           pa_pad_in,
    input logic [PA_W-1:0]           pa_pad_oe,
    input logic [PA_W-1:0]           pa_pad_out,
    input logic [PA_W-1:0]           pa_alt_en,
    input logic [PA_W-1:0]           pa_alt_out,
    input logic [PA_W-1:0]           pa_sync,
    input logic [PX_W-1:0]           px_pad_in,
    input logic [PX_W-1:0]           px_pad_oe,
    input logic [PX_W-1:0]           px_pad_out,
    input logic [PX_W-1:0]           px_alt_en,
    input logic [PX_W-1:0]           px_alt_out,
    input logic [PX_W-1:0]           px_sync,
    input logic [NUM_BUS*PORT_W-1:0] bus_oe,
    input logic [NUM_BUS*PORT_W-1:0] bus_out
);
    localparam int BLO = BUS_LO * PORT_W;
    localparam int BW  = NUM_BUS * PORT_W;
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_pad_oe & pa_pad_out & PA_OD_MASK) == '0); // R5
    AST_PA_PLAIN_ALT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_pad_oe & ~PA_OD_MASK & ~pa_alt_en) == '0); // R6
    AST_ALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_mode[1] |-> ((px_pad_oe & px_alt_en) == px_alt_en
                          && (px_pad_out & px_alt_en) == (px_alt_out & px_alt_en))); // R7
    AST_BUS_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mode[1] |-> (px_pad_oe[BLO +: BW] == bus_oe && px_pad_out[BLO +: BW] == bus_out)); // R9
    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (BUS_LO > 0 && wr_en && addr == ADDR_W'(NUM_DPORTS + 1)) |=>
        (px_alt_en[PORT_W-1:0] != '0 || px_pad_oe[PORT_W-1:0] == ~$past(wdata))); // R4
    AST_SYNC_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && addr == ADDR_W'(1)) |-> rdata == $past(px_pad_in[PORT_W-1:0], 2)); // R3
endmodule

bind gpio_mux_port gpio_mux_port_chk #(
    .PA_W(PA_W), .PA_OD_MASK(PA_OD_MASK), .PORT_W(PORT_W),
    .NUM_DPORTS(NUM_DPORTS), .BUS_LO(BUS_LO), .BUS_HI(BUS_HI)
) chk_i (.*);

// File: tb/gpio_mux_port_tb.sv
`timescale 1ns/1ps
module gpio_mux_port_tb_top;
    localparam int PA_W = 6;
    localparam logic [5:0] OD = 6'b001100;
    localparam int PX_W = 32;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [1:0] bus_mode = 2'b00;
    logic [5:0] pa_pad_in, pa_pad_oe, pa_pad_out, pa_sync;
    logic [5:0] pa_alt_en = '0, pa_alt_out = '0, pa_ext = '0, pa_ext_low = '0;
    logic [PX_W-1:0] px_pad_in, px_pad_oe, px_pad_out, px_sync;
    logic [PX_W-1:0] px_alt_en = '0, px_alt_out = '0, px_ext = '0;
    logic [23:0] bus_oe = '0, bus_out = '0;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign px_pad_in = (px_pad_oe & px_pad_out) | (~px_pad_oe & px_ext);
    assign pa_pad_in = (pa_pad_oe & pa_pad_out) | (~pa_pad_oe & ((OD & ~pa_ext_low) | (~OD & pa_ext)));

    gpio_mux_port dut_i (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        settle();
        for (int k = 0; k < 4; k++) begin
            addr = 4'(5 + k); #0.1;
            check("R1 dir reset", rdata, 8'hFF);
        end
        check("R1 pa oe", pa_pad_oe, 6'h00);
        check("R1 px oe", px_pad_oe, 32'h0);
        addr = 4'd0; #0.1;
        check("R1 pa released pulled up", rdata, 8'h0C);
        addr = 4'd15; #0.1;
        check("R2 unmapped", rdata, 8'h00);
    endtask

    task automatic t_rmw();
        @(negedge clk); pa_ext_low = 6'b000100;
        settle(); addr = 4'd0; #0.1;
        check("R10 read shows pulled-low pin", rdata, 8'h08);
        wr(4'd0, rdata | 8'h01);
        check("R10 pin2 now driven", pa_pad_oe[2], 1'b1);
        pa_ext_low = '0; settle(); addr = 4'd0; #0.1;
        check("R10 pin2 stays low", rdata[2], 1'b0);
        wr(4'd0, 8'h0C);
    endtask

    task automatic t_od();
        wr(4'd0, 8'h3B);
        check("R5 pin2 drives low", pa_pad_oe & OD, 6'b000100);
        check("R5 out low", pa_pad_out & OD, 6'h00);
        check("R6 plain pins undriven", pa_pad_oe & ~OD, 6'h00);
        check("R6 px untouched", px_pad_oe, 32'h0);
        wr(4'd0, 8'h0C);
    endtask

    task automatic t_dir();
        wr(4'd1, 8'hA5);
        wr(4'd5, 8'h0F);
        check("R4 oe", px_pad_oe[7:0], 8'hF0);
        wr(4'd5, 8'hF0);
        check("R4 oe low nibble", px_pad_oe[7:0], 8'h0F);
        check("R4 out", px_pad_out[3:0], 4'h5);
        px_ext[7:0] = 8'h30; settle(); addr = 4'd1; #0.1;
        check("R3 read pins not latch", rdata, 8'h35);
        addr = 4'd5; #0.1;
        check("R2 dir readback", rdata, 8'hF0);
        wr(4'd2, 8'h77);
        check("R6 port0 kept", px_pad_out[3:0], 4'h5);
        check("R6 port0 oe kept", px_pad_oe[7:0], 8'h0F);
        check("R8 sync shows driven", px_sync[3:0], 4'h5);
    endtask

    task automatic t_latency();
        addr = 4'd2; @(negedge clk); px_ext[15:8] = 8'hC3;
        @(negedge clk); #0.1;
        check("R3 not after one edge", rdata, 8'h00);
        @(negedge clk); #0.1;
        check("R3 after two edges", rdata, 8'hC3);
        check("R8 sync", px_sync[15:8], 8'hC3);
    endtask

    task automatic t_alt();
        @(negedge clk); px_alt_en[7:0] = 8'hF0; px_alt_out[7:0] = 8'hA0; #0.1;
        check("R7 alt oe", px_pad_oe[7:0], 8'hFF);
        check("R7 alt out", px_pad_out[7:4], 4'hA);
        pa_alt_en = 6'b010100; pa_alt_out = 6'b010100; #0.1;
        check("R7 pa alt", pa_pad_oe, 6'b010000);
        check("R7 pa alt out", pa_pad_out, 6'b010000);
        pa_alt_out = 6'b010000; #0.1;
        check("R7 od alt pulls low", pa_pad_oe, 6'b010100);
        px_alt_en = '0; pa_alt_en = '0;
    endtask

    task automatic t_bus();
        @(negedge clk);
        px_alt_en[15:8] = 8'hFF; px_alt_out[15:8] = 8'h00;
        bus_oe = 24'h0000FF; bus_out = 24'h00003C; bus_mode = 2'b10; #0.1;
        check("R9 bus oe", px_pad_oe[15:8], 8'hFF);
        check("R9 bus out over alt", px_pad_out[15:8], 8'h3C);
        check("R9 bus idle port", px_pad_oe[31:24], 8'h00);
        check("R9 port0 unaffected", px_pad_oe[7:0], 8'h0F);
        bus_mode = 2'b11; bus_oe = 24'hFF0000; #0.1;
        check("R9 mode11 port3", px_pad_oe[31:16], 16'hFF00);
        bus_mode = 2'b01; #0.1;
        check("R9 gpio alt back", px_pad_out[15:8], 8'h00);
        px_alt_en = '0; #0.1;
        check("R9 gpio dir input", px_pad_oe[31:8], 24'h0);
        bus_mode = 2'b00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rmw();
        t_od();
        t_dir();
        t_latency();
        t_alt();
        t_bus();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                #1000000;
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule